// File: doc/BRIEF.md
# Debounced Battery Swap Detector

This block decides when a battery has really been removed or swapped, as opposed to a contact bounce or a brief supply dip. It watches two digitized inputs: a supply undervoltage indicator and a presence comparator output that reads high when no battery is connected. Each input passes through its own persistence filter, which counts strobes of a 32768 Hz time base. The default qualification window is 16384 strobes, or half a second. A qualified presence loss raises a battery-fail flag. A qualified undervoltage raises an undervoltage-event flag. Either one puts the gauge into a hold state, and the gauge stays there until the host requests a soft restart.

The host clears the flags through write strobes that carry a data bit. Only a written 0 has any effect, and the battery-fail flag refuses to clear while the battery is still missing. A restart runs when reset is released and again on each soft restart request. It ends when the measurement sequencer reports that the initial open-circuit measurement is done. During a restart the block can drive a charge-inhibit output high, which holds the charger off while the open-circuit voltage is measured. A force input drives charge-inhibit high at any time.

Top module: `swap_guard`

## Requirements
- R1: When `uvlo_in` stays high for QUAL_TICKS consecutive tick strobes, `uv_event` rises on the clock edge that takes the last strobe. A shorter high period changes neither `uv_event` nor `hold`.
- R2: When `absent_in` stays high for QUAL_TICKS consecutive tick strobes, `bat_fail` rises on the clock edge that takes the last strobe. A shorter high period changes neither `bat_fail` nor `hold`.
- R3: A low input resets that input's qualification count to zero, so separate high periods never add up. Clock edges without a tick strobe do not advance the count.
- R4: A write of data 0 on `fail_wr` clears `bat_fail` only while `absent_in` is low. A write of data 1 has no effect.
- R5: A write of data 0 on `uv_wr` clears `uv_event`. A write of data 1 has no effect.
- R6: When a qualification falls in the same cycle as a clearing write or a soft restart request, the flag and `hold` are set.
- R7: `hold` rises with either qualification and stays high until a `soft_rst` strobe clears it.
- R8: After reset every output is low. `restarting` rises on the first clock edge after reset release and on the edge after each `soft_rst` strobe. It falls on the edge after `meas_done`.
- R9: During a restart, `chg_inhibit` is high only if `absent_in` was low and `vin_ok` was high in the cycle the restart started. Later changes of those inputs have no effect until the next restart.
- R10: `force_inh` high drives `chg_inhibit` high in the same cycle, whatever the restart state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe of the 32768 Hz time base |
| uvlo_in | input | 1 | Supply undervoltage indicator, high = under threshold |
| absent_in | input | 1 | Presence comparator, high = battery absent |
| vin_ok | input | 1 | Battery voltage above the charge-inhibit minimum |
| meas_done | input | 1 | Initial open-circuit measurement finished |
| fail_wr | input | 1 | Host write strobe for the battery-fail flag |
| fail_wdata | input | 1 | Data bit for the battery-fail write |
| uv_wr | input | 1 | Host write strobe for the undervoltage-event flag |
| uv_wdata | input | 1 | Data bit for the undervoltage write |
| soft_rst | input | 1 | Soft restart request strobe (self-clearing bit) |
| force_inh | input | 1 | Force charge-inhibit high |
| bat_fail | output | 1 | Qualified battery removal flag |
| uv_event | output | 1 | Qualified undervoltage flag |
| hold | output | 1 | Gauge held after a qualified swap |
| restarting | output | 1 | Restart sequence in progress |
| chg_inhibit | output | 1 | Charge-inhibit drive |

## Verification
Two functions can fall in the same cycle. A qualification can complete in the cycle where the host clears the matching flag or requests a soft restart. The bench holds `uvlo_in` high for one strobe short of the window. It then asserts a clearing write and `soft_rst` together with the final strobe. It expects `uv_event` and `hold` to be high afterwards while a restart also begins. A sweep of pulse lengths around the window, run on both inputs, pins down the boundary between short and qualifying events.

// File: rtl/swap_guard.sv
module swap_guard #(
  parameter int QUAL_TICKS = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic uvlo_in,
  input  logic absent_in,
  input  logic vin_ok,
  input  logic meas_done,
  input  logic fail_wr,
  input  logic fail_wdata,
  input  logic uv_wr,
  input  logic uv_wdata,
  input  logic soft_rst,
  input  logic force_inh,
  output logic bat_fail,
  output logic uv_event,
  output logic hold,
  output logic restarting,
  output logic chg_inhibit
);

  localparam int CW = $clog2(QUAL_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(QUAL_TICKS);
  localparam logic [CW-1:0] LAST = CW'(QUAL_TICKS - 1);

  logic [1:0] raw;
  logic [1:0] hit;
  logic       boot;
  logic       start;
  logic       cd_arm;

  assign raw = {absent_in, uvlo_in};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (!raw[g])              cnt <= '0;
      else if (tick && cnt != FULL)  cnt <= cnt + 1'b1;
    end
    assign hit[g] = raw[g] & tick & (cnt == LAST);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bat_fail <= 1'b0;
      uv_event <= 1'b0;
      hold     <= 1'b0;
    end else begin
      if (hit[1])                                   bat_fail <= 1'b1;
      else if (fail_wr && !fail_wdata && !absent_in) bat_fail <= 1'b0;
      if (hit[0])                                   uv_event <= 1'b1;
      else if (uv_wr && !uv_wdata)                   uv_event <= 1'b0;
      if (|hit)                                     hold <= 1'b1;
      else if (soft_rst)                            hold <= 1'b0;
    end
  end

  assign start = boot | soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot       <= 1'b1;
      restarting <= 1'b0;
      cd_arm     <= 1'b0;
    end else begin
      boot <= 1'b0;
      if (start) begin
        restarting <= 1'b1;
        cd_arm     <= !absent_in && vin_ok;
      end else if (meas_done) begin
        restarting <= 1'b0;
      end
    end
  end

  assign chg_inhibit = force_inh | (restarting & cd_arm);

  assert_uv_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_event) |-> $past(uvlo_in));
  assert_fail_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bat_fail) |-> $past(absent_in));
  assert_fail_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bat_fail) |-> $past(fail_wr && !fail_wdata && !absent_in));
  assert_uv_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uv_event) |-> $past(uv_wr && !uv_wdata));
  assert_hold_rel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(soft_rst));
  assert_restart_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(restarting) |-> $past(meas_done));

endmodule

// File: tb/swap_guard_tb.sv
module swap_guard_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, uvlo_in = 1'b0, absent_in = 1'b0, vin_ok = 1'b1, meas_done = 1'b0;
  logic fail_wr = 1'b0, fail_wdata = 1'b0, uv_wr = 1'b0, uv_wdata = 1'b0;
  logic soft_rst = 1'b0, force_inh = 1'b0;
  logic bat_fail, uv_event, hold, restarting, chg_inhibit;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  swap_guard #(.QUAL_TICKS(Q)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .uvlo_in(uvlo_in), .absent_in(absent_in),
    .vin_ok(vin_ok), .meas_done(meas_done), .fail_wr(fail_wr), .fail_wdata(fail_wdata),
    .uv_wr(uv_wr), .uv_wdata(uv_wdata), .soft_rst(soft_rst), .force_inh(force_inh),
    .bat_fail(bat_fail), .uv_event(uv_event), .hold(hold), .restarting(restarting),
    .chg_inhibit(chg_inhibit));

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_in(input int sel, input logic v);
    if (sel == 0) uvlo_in = v; else absent_in = v;
  endtask

  task automatic wr_flag(input int sel, input logic d);
    if (sel == 0) begin uv_wr = 1'b1; uv_wdata = d; end
    else begin fail_wr = 1'b1; fail_wdata = d; end
    cyc(1);
    uv_wr = 1'b0; fail_wr = 1'b0;
  endtask

  function automatic logic flag(input int sel);
    return (sel == 0) ? uv_event : bat_fail;
  endfunction

  task automatic restart_and_finish();
    soft_rst = 1'b1; cyc(1); soft_rst = 1'b0;
    meas_done = 1'b1; cyc(1); meas_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R8 reset bat_fail", bat_fail, 1'b0);
    chk("R8 reset uv_event", uv_event, 1'b0);
    chk("R8 reset hold", hold, 1'b0);
    chk("R8 reset restarting", restarting, 1'b0);
    chk("R8 reset chg_inhibit", chg_inhibit, 1'b0);
    rst_n = 1'b1;
    cyc(1);
    chk("R8 boot restart", restarting, 1'b1);
    chk("R9 boot inhibit armed", chg_inhibit, 1'b1);
    meas_done = 1'b1; cyc(1); meas_done = 1'b0;
    chk("R8 restart ends", restarting, 1'b0);
    chk("R9 inhibit released", chg_inhibit, 1'b0);

    // R1 / R2 sweep of pulse length around the window
    for (int sel = 0; sel < 2; sel++) begin
      for (int len = 1; len <= Q + 3; len++) begin
        logic exp;
        exp = (len >= Q);
        set_in(sel, 1'b1); cyc(len); set_in(sel, 1'b0); cyc(2);
        chk(sel == 0 ? "R1 uv flag vs length" : "R2 fail flag vs length", flag(sel), exp);
        chk(sel == 0 ? "R1 hold vs length" : "R2 hold vs length", hold, exp);
        if (exp) begin
          wr_flag(sel, 1'b1);
          chk(sel == 0 ? "R5 write 1 ignored" : "R4 write 1 ignored", flag(sel), 1'b1);
          wr_flag(sel, 1'b0);
          chk(sel == 0 ? "R5 write 0 clears" : "R4 write 0 clears", flag(sel), 1'b0);
          chk("R7 hold kept after clear", hold, 1'b1);
          soft_rst = 1'b1; cyc(1); soft_rst = 1'b0;
          chk("R7 soft reset releases hold", hold, 1'b0);
          chk("R8 soft reset restarts", restarting, 1'b1);
          chk("R9 inhibit armed on restart", chg_inhibit, 1'b1);
          meas_done = 1'b1; cyc(1); meas_done = 1'b0;
          chk("R8 restart ends", restarting, 1'b0);
        end
      end
    end

    // R4 clear blocked while absent
    absent_in = 1'b1; cyc(Q);
    chk("R2 fail at window", bat_fail, 1'b1);
    wr_flag(1, 1'b0);
    chk("R4 clear blocked while absent", bat_fail, 1'b1);
    absent_in = 1'b0; cyc(1);
    wr_flag(1, 1'b0);
    chk("R4 clear after presence", bat_fail, 1'b0);
    restart_and_finish();

    // R3 split pulses do not add up
    absent_in = 1'b1; cyc(Q - 3); absent_in = 1'b0; cyc(1);
    absent_in = 1'b1; cyc(Q - 3); absent_in = 1'b0; cyc(2);
    chk("R3 split pulses no fail", bat_fail, 1'b0);
    chk("R3 split pulses no hold", hold, 1'b0);

    // R3 no ticks, no progress
    tick = 1'b0; uvlo_in = 1'b1; cyc(3 * Q);
    chk("R3 no tick no event", uv_event, 1'b0);
    tick = 1'b1; cyc(Q - 1);
    chk("R3 one tick short", uv_event, 1'b0);
    cyc(1);
    chk("R3 ticks complete window", uv_event, 1'b1);
    uvlo_in = 1'b0; cyc(1);
    wr_flag(0, 1'b0);
    restart_and_finish();

    // R6 qualification meets clear and soft reset in the same cycle
    uvlo_in = 1'b1; cyc(Q - 1);
    chk("R6 pre-window", uv_event, 1'b0);
    uv_wr = 1'b1; uv_wdata = 1'b0; soft_rst = 1'b1;
    cyc(1);
    uv_wr = 1'b0; soft_rst = 1'b0; uvlo_in = 1'b0;
    chk("R6 set beats clear", uv_event, 1'b1);
    chk("R6 set beats hold release", hold, 1'b1);
    chk("R6 restart still starts", restarting, 1'b1);
    wr_flag(0, 1'b0);
    restart_and_finish();
    chk("R7 hold released", hold, 1'b0);

    // R9 arming sampled at start only
    absent_in = 1'b1; soft_rst = 1'b1; cyc(1); soft_rst = 1'b0; absent_in = 1'b0;
    chk("R9 absent at start restart", restarting, 1'b1);
    chk("R9 absent at start no inhibit", chg_inhibit, 1'b0);
    meas_done = 1'b1; cyc(1); meas_done = 1'b0;
    vin_ok = 1'b0; soft_rst = 1'b1; cyc(1); soft_rst = 1'b0;
    chk("R9 low vin no inhibit", chg_inhibit, 1'b0);
    vin_ok = 1'b1; cyc(2);
    chk("R9 later vin ignored", chg_inhibit, 1'b0);
    chk("R2 short absent no fail", bat_fail, 1'b0);

    // R10 force
    force_inh = 1'b1; #1;
    chk("R10 force during restart", chg_inhibit, 1'b1);
    meas_done = 1'b1; cyc(1); meas_done = 1'b0;
    chk("R10 force when idle", chg_inhibit, 1'b1);
    force_inh = 1'b0; #1;
    chk("R10 release force", chg_inhibit, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule